// File: doc/BRIEF.md
# Double-Write Protected Control Register Bank

This block holds a small bank of byte-wide control registers that must be shielded from a single stray store. The register bus sees each protected location as an ordinary read/write register. A new value only takes hold when software stores the same byte to the same location twice in a row. The first store captures the byte and raises a pending tag for that location. A second store that carries the same byte commits it. A second store that carries a different byte is discarded and disarms the tag.

Any store to another address, whether inside or outside the bank, disarms every pending tag, so a valid pair must be two back-to-back stores. Cycles without a store do not break a pair. To set or clear one bit, software does a read-modify-write and then repeats the same write. The committed values drive the block outputs directly, and reads return only committed values.

Top module: `dw_prot_bank`

## Requirements
- R1: The bank holds NUM_REGS (default 7) registers at addresses BASE_ADDR (default 0x30) through BASE_ADDR+NUM_REGS-1 (0x36). Register i sits at address BASE_ADDR+i and drives reg_out bits [8i+7:8i].
- R2: A store to a bank register whose tag is clear leaves every committed value unchanged. It captures the byte and arms that register's tag.
- R3: A store to the same register with the same byte, made while its tag is armed, commits the byte to reg_out on the next clock edge and clears the tag. A further store then counts as a new first store.
- R4: A store with a different byte, made while the tag is armed, is discarded and clears the tag. Two more identical stores are then needed to commit.
- R5: Any store to a different address clears every pending tag. A store outside the bank window changes no register.
- R6: Clock cycles with wr_en low between the two stores of a pair do not disarm the tag.
- R7: rd_data, registered one cycle after addr is presented, holds the committed value of the addressed register, never a pending byte. Addresses outside the window read 0x00.
- R8: A synchronous active-high reset sets all registers and rd_data to 0x00 and clears all tags.
- R9: A single-bit set or clear takes effect only when the modified byte is stored twice in a row. One store of it leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register bus address for reads and writes |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, one store per cycle while high |
| rd_data | output | DATA_W | Registered read data for the previous cycle's addr |
| reg_out | output | NUM_REGS*DATA_W | Committed register values, register i at [DATA_W*i +: DATA_W] |

## Verification
The hardest case to reach from the ports is a pending tag that has been disarmed without any visible change. A mismatch, a store to a neighbouring register, or a store outside the window all leave reg_out untouched. The stimulus therefore follows each disarming event with one store of the pending byte and checks that the register still holds its old value. Only a second identical store then commits it. The bench also reads a register while its tag is armed, to show that the pending byte never reaches rd_data.

// File: rtl/dw_pkg.sv
package dw_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_ARM    = 2'd1,
    SLOT_COMMIT = 2'd2,
    SLOT_DROP   = 2'd3
  } slot_act_e;
endpackage

// File: rtl/dw_addr_dec.sv
module dw_addr_dec #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_REGS  = 7,
  parameter int unsigned BASE_ADDR = 48,
  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  output logic                in_win,
  output logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] hit
);
  logic [ADDR_W-1:0] offset;

  // Unsigned wrap sends addresses below the base far out of the window.
  assign offset = addr - ADDR_W'(BASE_ADDR);
  assign in_win = (offset < ADDR_W'(NUM_REGS));
  assign idx    = offset[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit[g] = wr_en && in_win && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/dw_slot.sv
module dw_slot
  import dw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              wr_any,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              tag
);
  logic [DATA_W-1:0] cap_q;
  slot_act_e         act;

  always_comb begin
    act = SLOT_IDLE;
    if (hit) begin
      if (!tag)                act = SLOT_ARM;
      else if (wdata == cap_q) act = SLOT_COMMIT;
      else                     act = SLOT_DROP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      cap_q <= '0;
      tag   <= 1'b0;
    end else begin
      unique case (act)
        SLOT_ARM: begin
          cap_q <= wdata;
          tag   <= 1'b1;
        end
        SLOT_COMMIT: begin
          value <= cap_q;
          tag   <= 1'b0;
        end
        SLOT_DROP: tag <= 1'b0;
        default: if (wr_any) tag <= 1'b0;  // store elsewhere breaks the pair
      endcase
    end
  end
endmodule

// File: rtl/dw_prot_bank.sv
module dw_prot_bank #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_REGS  = 7,
  parameter int unsigned BASE_ADDR = 48,
  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       wr_en,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] reg_out
);
  logic                in_win;
  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] tag_vec;
  logic [DATA_W-1:0]   value [NUM_REGS];

  dw_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(addr), .wr_en(wr_en), .in_win(in_win), .idx(idx), .hit(hit)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    dw_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst(rst), .hit(hit[g]), .wr_any(wr_en),
      .wdata(wdata), .value(value[g]), .tag(tag_vec[g])
    );
    assign reg_out[g*DATA_W +: DATA_W] = value[g];
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (in_win) rd_data <= value[idx];
    else             rd_data <= '0;
  end
endmodule

// File: rtl/dw_prot_bank_chk.sv
module dw_prot_bank_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_REGS  = 7,
  parameter int unsigned BASE_ADDR = 48
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wdata,
  input logic                       wr_en,
  input logic [DATA_W-1:0]          rd_data,
  input logic [NUM_REGS*DATA_W-1:0] reg_out,
  input logic [NUM_REGS-1:0]        tags
);
  int unsigned       off;
  logic              inb;
  logic              own_tag;
  logic [DATA_W-1:0] sel_val;

  always_comb begin
    off     = int'(addr) - int'(BASE_ADDR);
    inb     = (int'(addr) >= int'(BASE_ADDR)) && (off < NUM_REGS);
    own_tag = 1'b0;
    sel_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (inb && off == i) begin
        own_tag = tags[i];
        sel_val = reg_out[i*DATA_W +: DATA_W];
      end
    end
  end

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (reg_out == '0 && tags == '0 && rd_data == '0));

  assert_single_tag_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tags));

  assert_outside_noeffect_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !inb) |=> ($stable(reg_out) && tags == '0));

  assert_first_store_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && inb && !own_tag) |=> ($stable(reg_out) && $countones(tags) == 1));

  assert_second_store_disarms_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && inb && own_tag) |=> (tags == '0));

  assert_commit_needs_tag_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && reg_out != $past(reg_out)) |-> $past(wr_en && tags != '0));

  assert_read_committed_R7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rd_data == $past(sel_val)));
endmodule

bind dw_prot_bank dw_prot_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_data(rd_data), .reg_out(reg_out), .tags(tag_vec)
);

// File: tb/dw_prot_bank_bench.sv
module dw_prot_bank_bench;
  localparam int NREG = 7;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addr  = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic wr_en = 1'b0;
  logic [7:0] rd_data;
  logic [NREG*8-1:0] reg_out;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  dw_prot_bank u_dw_prot_bank (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_data(rd_data), .reg_out(reg_out)
  );

  // {req, addr, wdata, register index checked, expected committed value}
  localparam int NV = 20;
  localparam logic [39:0] VEC [NV] = '{
    {8'd2, 8'h30, 8'hA5, 8'd0, 8'h00},  // R2 first store only arms
    {8'd3, 8'h30, 8'hA5, 8'd0, 8'hA5},  // R3 pair commits
    {8'd3, 8'h30, 8'hA5, 8'd0, 8'hA5},  // R3 third store re-arms
    {8'd4, 8'h30, 8'h5A, 8'd0, 8'hA5},  // R4 mismatch dropped
    {8'd4, 8'h30, 8'h5A, 8'd0, 8'hA5},  // R4 fresh first store
    {8'd4, 8'h30, 8'h5A, 8'd0, 8'h5A},  // R4 then commits
    {8'd2, 8'h31, 8'h11, 8'd1, 8'h00},  // R2 arm register 1
    {8'd5, 8'h40, 8'h11, 8'd1, 8'h00},  // R5 outside store breaks pair
    {8'd5, 8'h31, 8'h11, 8'd1, 8'h00},  // R5 counts as first again
    {8'd5, 8'h32, 8'h11, 8'd1, 8'h00},  // R5 neighbour store breaks pair
    {8'd5, 8'h31, 8'h11, 8'd1, 8'h00},  // R5 first again
    {8'd3, 8'h31, 8'h11, 8'd1, 8'h11},  // R3 commit
    {8'd1, 8'h36, 8'hFF, 8'd6, 8'h00},  // R1 top address
    {8'd1, 8'h36, 8'hFF, 8'd6, 8'hFF},  // R1 top register bits [55:48]
    {8'd5, 8'h37, 8'h77, 8'd6, 8'hFF},  // R5 just above window
    {8'd5, 8'h2F, 8'h77, 8'd0, 8'h5A},  // R5 just below window
    {8'd9, 8'h33, 8'h08, 8'd3, 8'h00},  // R9 bit set, one store
    {8'd9, 8'h33, 8'h08, 8'd3, 8'h08},  // R9 bit set, repeated
    {8'd9, 8'h33, 8'h09, 8'd3, 8'h08},  // R9 second bit, one store
    {8'd9, 8'h33, 8'h09, 8'd3, 8'h09}   // R9 second bit, repeated
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic store(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read(input logic [7:0] a);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] rbyte(input int i);
    return reg_out[i*8 +: 8];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    for (int i = 0; i < NREG; i++) check("R8 reset value", rbyte(i), 8'h00);
    check("R8 reset rd_data", rd_data, 8'h00);

    for (int v = 0; v < NV; v++) begin
      store(VEC[v][31:24], VEC[v][23:16]);
      check($sformatf("R%0d vector %0d", VEC[v][39:32], v),
            rbyte(int'(VEC[v][15:8])), VEC[v][7:0]);
    end
    check("R1 register 2 untouched", rbyte(2), 8'h00);

    // R6 idle cycles inside a pair
    store(8'h35, 8'hC3);
    repeat (3) @(negedge clk);
    check("R6 after first store", rbyte(5), 8'h00);
    store(8'h35, 8'hC3);
    check("R6 commit across idle gap", rbyte(5), 8'hC3);

    // R7 reads: pending byte never visible
    store(8'h34, 8'h99);
    read(8'h34);
    check("R7 read with tag armed", rd_data, 8'h00);
    read(8'h35);
    check("R7 read committed", rd_data, 8'hC3);
    read(8'h30);
    check("R7 read register 0", rd_data, 8'h5A);
    read(8'h50);
    check("R7 read outside window", rd_data, 8'h00);
    store(8'h34, 8'h99);
    check("R7 read between stores keeps tag", rbyte(4), 8'h99);

    // R8 reset drops a pending tag
    store(8'h32, 8'h66);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 reset clears register 0", rbyte(0), 8'h00);
    store(8'h32, 8'h66);
    check("R8 tag gone after reset", rbyte(2), 8'h00);
    store(8'h32, 8'h66);
    check("R8 new pair commits", rbyte(2), 8'h66);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule